// File: doc/BRIEF.md
# Serial-Controlled Debug Breakpoint and Trace Unit

This block sits beside a small processor core. It can stop the core, or record what the core has been doing, under commands from a host. The host reaches it only through a four-wire serial link of its own: clock, select, data in and data out. The link is separate from every bus of the core. The block watches three things: the core's data-memory accesses, its instruction retirements and its pipeline-stage contents. It raises a registered halt request when a programmed data address is touched or when a programmed number of instructions has retired.

While the core runs, the block keeps a circular record of the five most recently retired instruction addresses. A second, shorter record holds the addresses of the last two taken branches. When a halt is raised, the contents of every pipeline stage are frozen into snapshot registers. Both histories also stop recording while the core is halted. The host then reads any history entry or snapshot stage one word per frame and releases the core with a go command.

The host clock is oversampled in the system clock domain through a synchroniser. For this reason the host clock must run several times slower than the system clock.

Top module: `dbg_probe_unit`

## Requirements
- R1: A frame is 40 bits shifted MSB-first, each bit sampled on a rising edge of `lnk_clk` while `lnk_sel` is high. The first 8 bits are the command byte and the last 32 bits are the operand. A command acts only after its 40th bit. Driving `lnk_sel` low aborts a partial frame with no effect. The command byte's upper nibble selects the command: 1 arms the breakpoint at the operand address, 2 loads the step count, 3 is go, 4 reads instruction history, 5 reads a stage snapshot, 6 clears, 7 reads branch history. Any other value does nothing. The lower nibble is the entry index for reads.
- R2: After reset, `halt_req` is 0 and `halt_cause` is 0. The breakpoint and the step count are disarmed, and both histories read as empty.
- R3: While running with the breakpoint armed, a cycle with `mem_vld` high and `mem_addr` equal to the breakpoint address drives `halt_req` to 1 in the next cycle with `halt_cause` = 1. Any other address does not halt.
- R4: A step count N > 0 arms stepping. After exactly N retirements (`ret_vld`) while running, the unit halts with `halt_cause` = 2. Loading N = 0 disarms stepping. Any halt disarms stepping.
- R5: Once set, `halt_req` stays at 1 until a go command. Go clears `halt_req` and sets `halt_cause` to 0. While running, `halt_cause` is 0.
- R6: If a breakpoint match and the final counted retirement fall in the same cycle, `halt_cause` is 1.
- R7: Instruction-history read index 0 returns the oldest of the last five retired addresses and index 4 the newest. An index not yet filled since the last clear, or an index of 5 or more, returns 0.
- R8: While halted, retirements enter neither history and do not change the snapshot.
- R9: In the cycle a halt is raised, `stage_bus` slice k (bits 32k+31 down to 32k) is stored as snapshot stage k. A snapshot read with index k returns it, and an index of 4 or more returns 0.
- R10: Branch history holds the addresses of the last two retirements with `ret_br` high. Index 0 is the oldest, and unfilled entries read 0.
- R11: Clear empties both histories and disarms the breakpoint and stepping. It leaves `halt_req` and `halt_cause` unchanged.
- R12: During the operand of a read frame, `lnk_dout` carries the read word MSB-first. Bit k is valid while `lnk_clk` is low before the operand's k-th rising edge. Non-read frames shift out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_clk | input | 1 | Host serial clock, slower than clk |
| lnk_sel | input | 1 | Frame select, high during a frame |
| lnk_din | input | 1 | Host-to-unit serial data |
| lnk_dout | output | 1 | Unit-to-host serial data |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_br | input | 1 | Retiring instruction is a taken branch |
| mem_vld | input | 1 | A load or store is issued this cycle |
| mem_addr | input | 32 | Load or store data address |
| stage_bus | input | 128 | Current contents of the four pipeline stages |
| halt_req | output | 1 | Registered halt request to the core |
| halt_cause | output | 2 | 0 none, 1 breakpoint, 2 step count |

## Verification
The bench fills the five-entry history past its wrap point and then reads the oldest slot, an unfilled slot and an out-of-range index. A design with a wrong wrap arithmetic, or one that skips zero-filling, returns a stale or shifted address. It retires instructions while the core is halted and checks that the newest entry and the snapshot do not move; a design that keeps recording would show the ignored address. It lands a breakpoint match on the same edge as the last counted retirement and expects cause 1, so reversed priority reports cause 2. It also aborts a go frame halfway, runs a step count that must halt on exactly the third retirement, and checks that clear leaves the halt standing while emptying both histories.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int OPW  = 8;
  localparam int ARGW = 32;

  localparam logic [3:0] CMD_SETBP  = 4'h1;
  localparam logic [3:0] CMD_SETCNT = 4'h2;
  localparam logic [3:0] CMD_GO     = 4'h3;
  localparam logic [3:0] CMD_RDHIST = 4'h4;
  localparam logic [3:0] CMD_RDSNAP = 4'h5;
  localparam logic [3:0] CMD_CLEAR  = 4'h6;
  localparam logic [3:0] CMD_RDBR   = 4'h7;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_BKPT = 2'd1;
  localparam logic [1:0] CAUSE_STEP = 2'd2;
endpackage

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx #(
  parameter int OPW  = 8,
  parameter int ARGW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lnk_clk,
  input  logic            lnk_sel,
  input  logic            lnk_din,
  input  logic [ARGW-1:0] tx_data,
  output logic            lnk_dout,
  output logic [OPW-1:0]  op_code,
  output logic            cmd_fire,
  output logic [ARGW-1:0] cmd_arg
);
  localparam int TOT = OPW + ARGW;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] OP_LAST = CW'(OPW - 1);
  localparam logic [CW-1:0] FR_LAST = CW'(TOT - 1);
  localparam logic [CW-1:0] OP_N    = CW'(OPW);

  logic [2:0]      s_clk;
  logic [1:0]      s_din, s_sel;
  logic            rise, op_ready;
  logic [CW-1:0]   bit_cnt;
  logic [ARGW-1:0] tx_sh;

  assign rise     = s_clk[1] & ~s_clk[2];
  assign lnk_dout = tx_sh[ARGW-1];

  // host signals are oversampled: two stages for metastability, one for the edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk <= '0;
      s_din <= '0;
      s_sel <= '0;
    end else begin
      s_clk <= {s_clk[1:0], lnk_clk};
      s_din <= {s_din[0], lnk_din};
      s_sel <= {s_sel[0], lnk_sel};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      op_code  <= '0;
      cmd_arg  <= '0;
      tx_sh    <= '0;
      op_ready <= 1'b0;
      cmd_fire <= 1'b0;
    end else begin
      op_ready <= 1'b0;
      cmd_fire <= 1'b0;
      if (!s_sel[1]) begin
        bit_cnt <= '0;
      end else if (rise) begin
        if (bit_cnt < OP_N) begin
          op_code <= {op_code[OPW-2:0], s_din[1]};
          if (bit_cnt == OP_LAST) op_ready <= 1'b1;
        end else begin
          cmd_arg <= {cmd_arg[ARGW-2:0], s_din[1]};
          tx_sh   <= {tx_sh[ARGW-2:0], 1'b0};
          if (bit_cnt == FR_LAST) cmd_fire <= 1'b1;
        end
        bit_cnt <= (bit_cnt == FR_LAST) ? '0 : bit_cnt + 1'b1;
      end
      // read word is fetched once the command byte has settled
      if (op_ready) tx_sh <= tx_data;
    end
  end
endmodule

// File: rtl/dbg_hist.sv
module dbg_hist #(
  parameter int W     = 32,
  parameter int DEPTH = 5,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] WP_LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL    = (PW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW:0]   fill;
  int            pos;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp   <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wp <= (wp == WP_LAST) ? '0 : wp + 1'b1;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  // oldest entry sits fill slots behind the write pointer
  always_comb begin
    pos = int'(wp) + DEPTH - int'(fill) + int'(rd_idx);
    if (pos >= DEPTH) pos = pos - DEPTH;
    rd_data = (int'(rd_idx) < int'(fill)) ? mem[pos[PW-1:0]] : '0;
  end
endmodule

// File: rtl/dbg_probe_unit.sv
module dbg_probe_unit
  import dbg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NSTG   = 4,
  parameter int HDEPTH = 5,
  parameter int BDEPTH = 2,
  parameter int CNTW   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lnk_clk,
  input  logic             lnk_sel,
  input  logic             lnk_din,
  output logic             lnk_dout,
  input  logic             ret_vld,
  input  logic [AW-1:0]    ret_pc,
  input  logic             ret_br,
  input  logic             mem_vld,
  input  logic [AW-1:0]    mem_addr,
  input  logic [NSTG*DW-1:0] stage_bus,
  output logic             halt_req,
  output logic [1:0]       halt_cause
);
  localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

  logic [OPW-1:0]  op_code;
  logic [3:0]      cmd, idx;
  logic            cmd_fire;
  logic [ARGW-1:0] cmd_arg, rd_word;
  logic            halted, bp_armed, step_armed;
  logic [AW-1:0]   bp_addr;
  logic [CNTW-1:0] step_cnt;
  logic [1:0]      cause;
  logic            bp_hit, step_end, halt_now, cap, clr;
  logic [AW-1:0]   hist_rd, br_rd;
  logic [DW-1:0]   snap [NSTG];

  assign cmd      = op_code[7:4];
  assign idx      = op_code[3:0];
  assign bp_hit   = !halted && bp_armed && mem_vld && (mem_addr == bp_addr);
  assign step_end = !halted && step_armed && ret_vld && (step_cnt == CNTW'(1));
  assign halt_now = bp_hit || step_end;
  assign cap      = ret_vld && !halted;
  assign clr      = cmd_fire && (cmd == CMD_CLEAR);

  assign halt_req   = halted;
  assign halt_cause = cause;

  dbg_serial_rx #(.OPW(OPW), .ARGW(ARGW)) u_rx (
    .clk(clk), .rst(rst), .lnk_clk(lnk_clk), .lnk_sel(lnk_sel),
    .lnk_din(lnk_din), .tx_data(rd_word), .lnk_dout(lnk_dout),
    .op_code(op_code), .cmd_fire(cmd_fire), .cmd_arg(cmd_arg)
  );

  dbg_hist #(.W(AW), .DEPTH(HDEPTH), .IW(4)) u_hist (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(cap), .wr_data(ret_pc),
    .rd_idx(idx), .rd_data(hist_rd)
  );

  generate
    if (BDEPTH > 0) begin : g_br
      dbg_hist #(.W(AW), .DEPTH(BDEPTH), .IW(4)) u_br (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(cap && ret_br),
        .wr_data(ret_pc), .rd_idx(idx), .rd_data(br_rd)
      );
    end else begin : g_no_br
      assign br_rd = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      cause      <= CAUSE_NONE;
      bp_armed   <= 1'b0;
      bp_addr    <= '0;
      step_armed <= 1'b0;
      step_cnt   <= '0;
    end else begin
      if (halt_now) begin
        halted     <= 1'b1;
        cause      <= bp_hit ? CAUSE_BKPT : CAUSE_STEP;
        step_armed <= 1'b0;
      end else if (cap && step_armed) begin
        step_cnt <= step_cnt - 1'b1;
      end
      if (cmd_fire) begin
        case (cmd)
          CMD_SETBP: begin
            bp_addr  <= cmd_arg[AW-1:0];
            bp_armed <= 1'b1;
          end
          CMD_SETCNT: begin
            step_cnt   <= cmd_arg[CNTW-1:0];
            step_armed <= (cmd_arg[CNTW-1:0] != '0);
          end
          CMD_GO: begin
            halted <= 1'b0;
            cause  <= CAUSE_NONE;
          end
          CMD_CLEAR: begin
            bp_armed   <= 1'b0;
            step_armed <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NSTG; k++) begin
      if (rst) snap[k] <= '0;
      else if (halt_now) snap[k] <= stage_bus[k*DW +: DW];
    end
  end

  always_comb begin
    case (cmd)
      CMD_RDHIST: rd_word = ARGW'(hist_rd);
      CMD_RDBR:   rd_word = ARGW'(br_rd);
      CMD_RDSNAP: rd_word = (int'(idx) < NSTG) ? ARGW'(snap[idx[SW-1:0]]) : '0;
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dbg_probe_chk.sv
module dbg_probe_chk
  import dbg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            halt_req,
  input logic [1:0]      halt_cause,
  input logic            mem_vld,
  input logic [AW-1:0]   mem_addr,
  input logic            ret_vld,
  input logic            bp_armed,
  input logic [AW-1:0]   bp_addr,
  input logic            step_armed,
  input logic [CNTW-1:0] step_cnt,
  input logic            cmd_fire,
  input logic [3:0]      cmd
);
  a_r3_bp_halts: assert property (@(posedge clk) disable iff (rst)
    (!halt_req && !cmd_fire && bp_armed && mem_vld && mem_addr == bp_addr)
    |=> (halt_req && halt_cause == CAUSE_BKPT));

  a_r6_bp_beats_step: assert property (@(posedge clk) disable iff (rst)
    (!halt_req && !cmd_fire && bp_armed && mem_vld && mem_addr == bp_addr &&
     step_armed && ret_vld && step_cnt == CNTW'(1))
    |=> (halt_cause == CAUSE_BKPT));

  a_r4_step_halts: assert property (@(posedge clk) disable iff (rst)
    (!halt_req && !cmd_fire && step_armed && ret_vld && step_cnt == CNTW'(1) &&
     !(bp_armed && mem_vld && mem_addr == bp_addr))
    |=> (halt_req && halt_cause == CAUSE_STEP));

  a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !(cmd_fire && cmd == CMD_GO)) |=> halt_req);

  a_r5_go_releases: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && cmd == CMD_GO) |=> (!halt_req && halt_cause == CAUSE_NONE));

  a_r5_no_cause_running: assert property (@(posedge clk) disable iff (rst)
    !halt_req |-> (halt_cause == CAUSE_NONE));
endmodule

bind dbg_probe_unit dbg_probe_chk #(.AW(AW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .halt_req(halt_req), .halt_cause(halt_cause),
  .mem_vld(mem_vld), .mem_addr(mem_addr), .ret_vld(ret_vld),
  .bp_armed(bp_armed), .bp_addr(bp_addr), .step_armed(step_armed),
  .step_cnt(step_cnt), .cmd_fire(cmd_fire), .cmd(cmd)
);

// File: tb/test_dbg_probe_unit.sv
`timescale 1ns/1ps
module test_dbg_probe_unit;
  localparam int HALF = 8;

  logic clk = 0, rst = 1;
  logic lnk_clk = 0, lnk_sel = 0, lnk_din = 0, lnk_dout;
  logic ret_vld = 0, ret_br = 0, mem_vld = 0;
  logic [31:0] ret_pc = 0, mem_addr = 0;
  logic [127:0] stage_bus = 0;
  logic halt_req;
  logic [1:0] halt_cause;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] got_q[$];

  always #2 clk = ~clk;

  dbg_probe_unit i_dbg_probe_unit (
    .clk(clk), .rst(rst), .lnk_clk(lnk_clk), .lnk_sel(lnk_sel),
    .lnk_din(lnk_din), .lnk_dout(lnk_dout), .ret_vld(ret_vld),
    .ret_pc(ret_pc), .ret_br(ret_br), .mem_vld(mem_vld),
    .mem_addr(mem_addr), .stage_bus(stage_bus), .halt_req(halt_req),
    .halt_cause(halt_cause)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected words as read frames complete
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [31:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, g, e);
      end
    end
  end

  task automatic sbit(input logic b, output logic rb);
    repeat (HALF) @(negedge clk);
    lnk_din = b;
    lnk_clk = 0;
    repeat (HALF) @(negedge clk);
    rb = lnk_dout;
    lnk_clk = 1;
  endtask

  task automatic frame(input logic [7:0] op, input logic [31:0] arg, input int nbits, output logic [31:0] word);
    logic rb;
    word = 0;
    lnk_sel = 1;
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) sbit(op[7-i], rb);
      else begin
        sbit(arg[39-i], rb);
        word = {word[30:0], rb};
      end
    end
    repeat (HALF) @(negedge clk);
    lnk_clk = 0;
    lnk_sel = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [31:0] arg);
    logic [31:0] w;
    frame(op, arg, 40, w);
  endtask

  // driver: pushes the expected word, then performs the read frame
  task automatic rd(input logic [7:0] op, input logic [31:0] exp, input string tag);
    logic [31:0] w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(op, 32'h0, 40, w);
    got_q.push_back(w);
  endtask

  task automatic retire(input logic [31:0] pc, input logic br);
    @(negedge clk);
    ret_vld = 1; ret_pc = pc; ret_br = br;
    @(negedge clk);
    ret_vld = 0; ret_br = 0;
  endtask

  task automatic access(input logic [31:0] a);
    @(negedge clk);
    mem_vld = 1; mem_addr = a;
    @(negedge clk);
    mem_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(halt_req === 0, "R2 halt after reset", 32'(halt_req), 0);
    chk(halt_cause === 0, "R2 cause after reset", 32'(halt_cause), 0);
    rd(8'h40, 32'h0, "R2 history empty after reset");

    retire(32'h100, 0); retire(32'h104, 1); retire(32'h108, 0);
    rd(8'h40, 32'h100, "R7 oldest partial");
    rd(8'h42, 32'h108, "R7 newest partial");
    rd(8'h43, 32'h0, "R7 unfilled entry zero");
    rd(8'h70, 32'h104, "R10 branch entry");
    rd(8'h71, 32'h0, "R10 branch unfilled");

    retire(32'h10C, 0); retire(32'h110, 0); retire(32'h114, 0); retire(32'h118, 0);
    rd(8'h40, 32'h108, "R7 oldest after wrap");
    rd(8'h44, 32'h118, "R7 newest after wrap");
    rd(8'h45, 32'h0, "R7 index beyond depth");

    cmd(8'h10, 32'h2000);
    access(32'h1FFC);
    chk(halt_req === 0, "R3 other address no halt", 32'(halt_req), 0);
    stage_bus = {32'hCAFE_0003, 32'hBEEF_0002, 32'h1234_0001, 32'h8000_0000};
    access(32'h2000);
    chk(halt_req === 1, "R3 breakpoint halts", 32'(halt_req), 1);
    chk(halt_cause === 1, "R3 cause breakpoint", 32'(halt_cause), 1);
    stage_bus = '1;
    retire(32'h999, 1);
    rd(8'h44, 32'h118, "R8 history frozen while halted");
    rd(8'h71, 32'h0, "R8 branch history frozen");
    rd(8'h50, 32'h8000_0000, "R9 snapshot stage 0");
    rd(8'h53, 32'hCAFE_0003, "R9 snapshot stage 3");
    rd(8'h54, 32'h0, "R9 snapshot index beyond stages");

    frame(8'h30, 32'h0, 20, w);
    chk(halt_req === 1, "R1 aborted go frame ignored", 32'(halt_req), 1);
    cmd(8'hF0, 32'h0);
    chk(halt_req === 1, "R1 unknown command ignored", 32'(halt_req), 1);

    cmd(8'h30, 32'h0);
    chk(halt_req === 0, "R5 go releases", 32'(halt_req), 0);
    chk(halt_cause === 0, "R5 go clears cause", 32'(halt_cause), 0);

    cmd(8'h20, 32'd3);
    retire(32'h200, 0); retire(32'h204, 0);
    chk(halt_req === 0, "R4 no halt before count", 32'(halt_req), 0);
    retire(32'h208, 0);
    chk(halt_req === 1, "R4 halt after N", 32'(halt_req), 1);
    chk(halt_cause === 2, "R4 cause step", 32'(halt_cause), 2);
    rd(8'h40, 32'h114, "R7 oldest after step");
    rd(8'h44, 32'h208, "R7 step instruction recorded");

    cmd(8'h30, 32'h0);
    cmd(8'h20, 32'd0);
    for (int i = 0; i < 5; i++) retire(32'h300 + 32'(4*i), 0);
    chk(halt_req === 0, "R4 zero count disarms", 32'(halt_req), 0);

    cmd(8'h20, 32'd1);
    @(negedge clk);
    ret_vld = 1; ret_pc = 32'h8000_0001; ret_br = 1;
    mem_vld = 1; mem_addr = 32'h2000;
    @(negedge clk);
    ret_vld = 0; ret_br = 0; mem_vld = 0;
    @(negedge clk);
    chk(halt_req === 1, "R6 halted on tie", 32'(halt_req), 1);
    chk(halt_cause === 1, "R6 breakpoint wins tie", 32'(halt_cause), 1);
    rd(8'h44, 32'h8000_0001, "R12 word with both end bits set");
    rd(8'h70, 32'h104, "R10 oldest branch");
    rd(8'h71, 32'h8000_0001, "R10 newest branch");

    cmd(8'h60, 32'h0);
    chk(halt_req === 1, "R11 clear keeps halt", 32'(halt_req), 1);
    chk(halt_cause === 1, "R11 clear keeps cause", 32'(halt_cause), 1);
    rd(8'h40, 32'h0, "R11 history emptied");
    rd(8'h70, 32'h0, "R11 branch history emptied");
    cmd(8'h30, 32'h0);
    access(32'h2000);
    chk(halt_req === 0, "R11 breakpoint disarmed", 32'(halt_req), 0);
    retire(32'h400, 0);
    rd(8'h40, 32'h400, "R11 history refills after clear");
    rd(8'h41, 32'h0, "R7 unfilled after clear");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads compared", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule